// File: doc/BRIEF.md
# UART Baud Divider with Interval Timer

This block divides the system clock by a programmable 16-bit value to produce the 16x oversampling strobe that a UART's transmitter and receiver shift on. With a divisor D, the strobe recurs every D clock cycles, so the serial bit rate is the clock frequency divided by 16 × D.

When both the transmit and the receive enables are low, the same reload counter can serve as a general-purpose periodic timer. Software turns the UART off, loads the divisor, then sets the timer-mode control bit. From then on the block raises a sticky interrupt request every D clock cycles, and software acknowledges it with a write-one-to-clear strobe.

A small byte-wide write port holds the divisor bytes and the control bit. Divisor writes are accepted only while the UART is off. Any accepted divisor write restarts the count.

Top module: `uart_baud_timer`

## Requirements
- R1: After reset, `baud_tick` and `irq` are low, the divisor is 0 and timer mode is off.
- R2: While `tx_en` or `rx_en` is high, `baud_tick` is a one-cycle pulse that recurs every D clock cycles, where D is the divisor (1 to 65535).
- R3: After an idle period, the first `baud_tick` appears D clock edges after the first edge that sees an enable high, so the count always starts from a full reload.
- R4: A divisor write at address 0 (low byte) or address 1 (high byte) takes effect only when `tx_en` and `rx_en` are both low. Otherwise it is ignored and the running period is unchanged.
- R5: An accepted divisor write restarts the count, and the next timeout follows D clock edges after the write edge, with D the new value.
- R6: Bit 0 of the control register (address 2) selects timer mode. This bit may be written at any time. With the bit set and both enables low, `irq` sets every D clock cycles and `baud_tick` stays low.
- R7: `irq` stays high until a cycle with `irq_clr` high. A timeout in that same cycle keeps `irq` high.
- R8: While either enable is high, `irq` never sets, even with timer mode on. With both enables low and timer mode off, neither output pulses.
- R9: A divisor of 0 acts as 65536 and gives a period of 65536 cycles, so the counter never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 control |
| wr_data | input | 8 | Write data |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt request |
| baud_tick | output | 1 | One-cycle 16x oversampling strobe |
| irq | output | 1 | Sticky timer interrupt request |

## Verification
The hardest case to reach is a timer timeout that lands in the same cycle as the clear strobe, because the request is already high and the clear would normally hide the new event. The bench reaches it in two ways. With a divisor of 1, a timeout occurs on every edge, so every clear coincides with one. With a divisor of 5, the bench counts edges from a known timeout and raises the clear exactly on the fifth. The bench also shows that a divisor write has no effect while the UART runs. It does this by disabling and re-enabling the UART and measuring that the first tick still arrives after the old period.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   typedef enum logic [1:0] {
      UBT_IDLE  = 2'd0,
      UBT_BAUD  = 2'd1,
      UBT_TIMER = 2'd2
   } ubt_mode_e;

   // bit of the control register that selects timer mode
   localparam int unsigned UBT_CTRL_TMR_BIT = 0;
endpackage

// File: rtl/ubt_regs.sv
module ubt_regs
   import ubt_pkg::*;
#(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned REG_W  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              uart_on,
   output logic [DIV_W-1:0]  div_q,
   output logic [DIV_W-1:0]  div_next,
   output logic              restart,
   output logic              tmr_mode
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned NB        = DIV_W / REG_W;
   localparam int unsigned CTRL_ADDR = NB;

   logic [NB-1:0] hit;

   genvar b;
   generate
      for (b = 0; b < NB; b++) begin : g_byte
         logic [REG_W-1:0] byte_q;

         assign hit[b] = wr_en && !uart_on && (wr_addr == ADDR_W'(b));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (hit[b])
               byte_q <= wr_data;
         end

         assign div_q[b*REG_W +: REG_W]    = byte_q;
         assign div_next[b*REG_W +: REG_W] = hit[b] ? wr_data : byte_q;
      end
   endgenerate

   assign restart = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_mode <= 1'b0;
      else if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)))
         tmr_mode <= wr_data[UBT_CTRL_TMR_BIT];
   end

   // R4: the divisor is frozen while the UART is running
   assert_div_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uart_on |=> $stable(div_q));
endmodule

// File: rtl/ubt_count.sv
module ubt_count
   import ubt_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ubt_mode_e        mode,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_next,
   output logic             expire
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt_q;
   logic             running;
   logic             at_zero;

   assign running = (mode != UBT_IDLE);
   assign at_zero = (cnt_q == '0);
   assign expire  = running && !restart && at_zero;

   // Counts div-1 down to 0; divisor 0 wraps to all ones, giving 2**DIV_W cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '1;
      else if (!running || restart || at_zero)
         cnt_q <= div_next - ONE;
      else
         cnt_q <= cnt_q - ONE;
   end

   // R5: an accepted divisor write loads the new reload value
   assert_restart_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == $past(div_next) - ONE));

   // R3: while idle the counter sits at the full reload value
   assert_idle_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UBT_IDLE) |=> (cnt_q == $past(div_next) - ONE));
endmodule

// File: rtl/ubt_events.sv
module ubt_events
   import ubt_pkg::*;
#(
   parameter bit REG_TICK = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ubt_mode_e mode,
   input  logic      expire,
   input  logic      irq_clr,
   output logic      baud_tick,
   output logic      irq
);
   timeunit 1ns;
   timeprecision 1ps;

   logic tick_raw;
   logic tmr_hit;
   logic irq_q;

   assign tick_raw = expire && (mode == UBT_BAUD);
   assign tmr_hit  = expire && (mode == UBT_TIMER);

   generate
      if (REG_TICK) begin : g_tick_reg
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tick_q <= 1'b0;
            else
               tick_q <= tick_raw;
         end
         assign baud_tick = tick_q;

         // R8: a tick follows only a cycle spent in UART mode
         assert_tick_in_baud_R8: assert property (@(posedge clk) disable iff (!rst_n)
            baud_tick |-> ($past(mode) == UBT_BAUD));
      end else begin : g_tick_comb
         assign baud_tick = tick_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (tmr_hit)
         irq_q <= 1'b1;
      else if (irq_clr)
         irq_q <= 1'b0;
   end

   assign irq = irq_q;

   // R7: the request holds until cleared
   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !irq_clr) |=> irq_q);

   // R7: a clear outside timer mode always drops the request
   assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && (mode != UBT_TIMER)) |=> !irq_q);

   // R6: the request only rises out of timer mode
   assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> ($past(mode) == UBT_TIMER));
endmodule

// File: rtl/uart_baud_timer.sv
module uart_baud_timer
   import ubt_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned ADDR_W   = 2,
   parameter bit          REG_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              irq_clr,
   output logic              baud_tick,
   output logic              irq
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned NB = DIV_W / REG_W;

   generate
      if ((DIV_W % REG_W) != 0 || NB == 0) begin : g_bad_width
         $error("divisor width must be a whole number of register bytes");
      end
      if ((1 << ADDR_W) <= NB) begin : g_bad_addr
         $error("address width too small for divisor bytes plus control");
      end
      if (REG_W <= UBT_CTRL_TMR_BIT) begin : g_bad_ctrl
         $error("register too narrow for the timer-mode bit");
      end
   endgenerate

   logic             uart_on;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_next;
   logic             restart;
   logic             tmr_mode;
   logic             expire;
   ubt_mode_e        mode;

   assign uart_on = tx_en || rx_en;

   always_comb begin
      if (uart_on)
         mode = UBT_BAUD;
      else if (tmr_mode)
         mode = UBT_TIMER;
      else
         mode = UBT_IDLE;
   end

   ubt_regs #(
      .DIV_W  (DIV_W),
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .uart_on  (uart_on),
      .div_q    (div_q),
      .div_next (div_next),
      .restart  (restart),
      .tmr_mode (tmr_mode)
   );

   ubt_count #(
      .DIV_W (DIV_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .restart  (restart),
      .div_next (div_next),
      .expire   (expire)
   );

   ubt_events #(
      .REG_TICK (REG_TICK)
   ) u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .expire    (expire),
      .irq_clr   (irq_clr),
      .baud_tick (baud_tick),
      .irq       (irq)
   );

   // R6: a rising interrupt never coincides with a baud tick
   assert_tick_irq_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !$past(irq)) |-> !baud_tick);

   // R1: the divisor register is zero from reset until a write
   assert_div_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && rst_n) |-> (div_q == '0));
endmodule

// File: tb/uart_baud_timer_test.sv
module uart_baud_timer_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tx_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       irq_clr = 1'b0;
   logic       baud_tick;
   logic       irq;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   uart_baud_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .tx_en     (tx_en),
      .rx_en     (rx_en),
      .irq_clr   (irq_clr),
      .baud_tick (baud_tick),
      .irq       (irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      cyc();
      wr_en   = 1'b0;
   endtask

   task automatic set_div(input int d);
      wr(2'd0, 8'(d));
      wr(2'd1, 8'(d >> 8));
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1;
      cyc();
      irq_clr = 1'b0;
   endtask

   // counts edges until the chosen output is high; other = cycles the other output was high
   task automatic wait_ev(input bit use_irq, output int c, output int other);
      bit seen = 1'b0;
      c = 0;
      other = 0;
      while (!seen && c < 70000) begin
         cyc();
         c++;
         if (use_irq ? baud_tick : irq) other++;
         seen = use_irq ? irq : baud_tick;
      end
   endtask

   task automatic run_uart(input int d, input bit use_rx);
      int c, o, o2;
      set_div(d);
      if (use_rx) rx_en = 1'b1; else tx_en = 1'b1;
      wait_ev(1'b0, c, o);
      chk(c == d, "R3 first tick", c, d);
      if (d > 1) begin
         cyc();
         chk(baud_tick == 1'b0, "R2 tick width", int'(baud_tick), 0);
         wait_ev(1'b0, c, o2);
         chk(c + 1 == d, "R2 period", c + 1, d);
      end else begin
         wait_ev(1'b0, c, o2);
         chk(c == 1, "R2 period", c, 1);
      end
      chk(o + o2 == 0, "R8 no irq in UART mode", o + o2, 0);
      tx_en = 1'b0;
      rx_en = 1'b0;
   endtask

   task automatic run_timer(input int d);
      int c, o, o2;
      set_div(d);
      pulse_clr();
      wr(2'd2, 8'h01);
      wait_ev(1'b1, c, o);
      chk(c == d, "R6 first timeout", c, d);
      pulse_clr();
      chk(irq == 1'b0, "R7 clear", int'(irq), 0);
      wait_ev(1'b1, c, o2);
      chk(c + 1 == d, "R6 interval", c + 1, d);
      chk(o + o2 == 0, "R6 no tick in timer mode", o + o2, 0);
      wr(2'd2, 8'h00);
      pulse_clr();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int c, o, ticks, irqs;
      repeat (3) @(negedge clk);
      chk(baud_tick == 1'b0, "R1 tick reset", int'(baud_tick), 0);
      chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);
      rst_n = 1'b1;
      cyc();

      // R1 / R9: reset divisor is 0, which acts as 65536
      rx_en = 1'b1;
      wait_ev(1'b0, c, o);
      chk(c == 65536, "R9 divisor zero period", c, 65536);
      rx_en = 1'b0;
      cyc();

      // R2 / R3 sweep
      for (int d = 1; d <= 24; d++) run_uart(d, d[0]);
      run_uart(255, 1'b0);
      run_uart(256, 1'b1);
      run_uart(300, 1'b0);
      run_uart(1000, 1'b1);

      // R4: divisor write while UART on is ignored
      set_div(7);
      tx_en = 1'b1;
      wait_ev(1'b0, c, o);
      chk(c == 7, "R4 baseline", c, 7);
      wr(2'd0, 8'd3);
      wait_ev(1'b0, c, o);
      chk(c + 1 == 7, "R4 period unchanged", c + 1, 7);
      tx_en = 1'b0;
      cyc();
      rx_en = 1'b1;
      wait_ev(1'b0, c, o);
      chk(c == 7, "R4 divisor kept", c, 7);
      rx_en = 1'b0;
      cyc();

      // R6 timer sweep
      for (int d = 2; d <= 12; d++) run_timer(d);

      // R7: clear coinciding with a timeout keeps the request
      set_div(5);
      wr(2'd2, 8'h01);
      wait_ev(1'b1, c, o);
      chk(c == 5, "R6 timeout d=5", c, 5);
      pulse_clr();
      chk(irq == 1'b0, "R7 cleared", int'(irq), 0);
      repeat (3) cyc();
      chk(irq == 1'b0, "R7 still clear", int'(irq), 0);
      pulse_clr();
      chk(irq == 1'b1, "R7 coincident clear keeps irq", int'(irq), 1);
      repeat (20) cyc();
      chk(irq == 1'b1, "R7 sticky", int'(irq), 1);
      wr(2'd2, 8'h00);
      pulse_clr();
      chk(irq == 1'b0, "R7 clear when idle", int'(irq), 0);

      set_div(1);
      wr(2'd2, 8'h01);
      chk(irq == 1'b0, "R6 no irq before first edge", int'(irq), 0);
      cyc();
      chk(irq == 1'b1, "R6 d=1 timeout", int'(irq), 1);
      pulse_clr();
      chk(irq == 1'b1, "R7 d=1 clear overlaps timeout", int'(irq), 1);
      wr(2'd2, 8'h00);
      pulse_clr();

      // R5: write restarts the count
      set_div(50);
      wr(2'd2, 8'h01);
      wait_ev(1'b1, c, o);
      chk(c == 50, "R5 old period", c, 50);
      pulse_clr();
      repeat (10) cyc();
      wr(2'd0, 8'd20);
      wait_ev(1'b1, c, o);
      chk(c == 20, "R5 restart from new value", c, 20);
      wr(2'd2, 8'h00);
      pulse_clr();

      // R8: timer bit set while UART on gives ticks but no irq
      set_div(9);
      ticks = 0;
      irqs = 0;
      tx_en   = 1'b1;
      wr_en   = 1'b1;
      wr_addr = 2'd2;
      wr_data = 8'h01;
      for (int i = 0; i < 60; i++) begin
         cyc();
         wr_en = 1'b0;
         if (baud_tick) ticks++;
         if (irq) irqs++;
      end
      chk(ticks == 6, "R8 ticks with timer bit set", ticks, 6);
      chk(irqs == 0, "R8 no irq while UART on", irqs, 0);
      wr(2'd2, 8'h00);
      tx_en = 1'b0;
      ticks = 0;
      irqs = 0;
      for (int i = 0; i < 100; i++) begin
         cyc();
         if (baud_tick) ticks++;
         if (irq) irqs++;
      end
      chk(ticks == 0, "R8 idle no tick", ticks, 0);
      chk(irqs == 0, "R8 idle no irq", irqs, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule